// File: doc/BRIEF.md
# Turbo Decoder Soft-Input Formatter

This block sits in front of a turbo decoder and turns a stream of soft-decision log-likelihood ratios (LLRs) into the packed word stream the decoder reads. Each accepted input beat carries three N-bit two's-complement LLRs (systematic, first parity, second parity) and a three-bit erasure mask. The block clears erased positions to zero and moves the one unusable code, a one followed by all zeros, to the nearest usable negative value. It then writes the three values into one 3N-bit output word. A positive LLR favours a 1, and zero means both values are equally likely.

The block length K comes from a configuration input and is sampled on the first beat of each block. The beat that carries data index K-1 also carries the twelve trellis-termination LLRs of the two constituent encoders, with an erasure mask of their own. Once that beat is accepted, the block stops taking input and emits four tail words in an interleaved arrangement. The next block is accepted only after that. Output words leave through a single registered valid/ready stage that carries start- and end-of-packet flags.

Top module: `llr_stream_packer`

## Requirements
- R1: Data word i (0 <= i < K) carries the cleaned systematic LLR i in bits N-1..0, parity-1 LLR i in bits 2N-1..N and parity-2 LLR i in bits 3N-1..2N.
- R2: Any LLR equal to the code 1 followed by N-1 zeros is output as 1 followed by N-2 zeros and a final 1 (the most negative usable value). All other unerased values pass unchanged.
- R3: A field whose erasure bit is set (in_punct bit 0 systematic, bit 1 parity 1, bit 2 parity 2) is output as zero, whatever its input value.
- R4: The in_tail bus holds twelve N-bit slots. Slot s sits at bits s*N+N-1..s*N. Slots 0..2 are the first encoder's systematic tail t0..t2, slots 3..5 its parity tail t0..t2, and slots 6..11 the same for the second encoder. Word K is {sys t1, par t0, sys t0} and word K+1 is {par t2, sys t2, par t1}, each listed from high field to low field, using the first encoder.
- R5: Words K+2 and K+3 use the R4 arrangement with the second encoder's slots.
- R6: Tail LLRs are cleaned by the rules of R2 and R3. in_tail_punct bit s erases slot s.
- R7: K (1..K_MAX) is taken from cfg_k on the first beat of a block. Changes of cfg_k during the rest of the block have no effect on its length.
- R8: out_sop is high on word 0 only and out_eop on word K+3 only, so each block is exactly K+4 words long.
- R9: in_ready stays low from the acceptance of data beat K-1 until the cycle in which word K+3 is handed over.
- R10: While out_valid is high and out_ready is low, out_data, out_sop and out_eop hold steady. No word is dropped or repeated.
- R11: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_k | input | KW | Block length K, sampled at the first beat of a block |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted this cycle when high with in_valid |
| in_sys | input | N | Systematic LLR |
| in_par1 | input | N | First parity LLR |
| in_par2 | input | N | Second parity LLR |
| in_punct | input | 3 | Erasure mask: bit 0 systematic, 1 parity 1, 2 parity 2 |
| in_tail | input | 12*N | Tail LLR slots, sampled with data beat K-1 |
| in_tail_punct | input | 12 | Erasure mask for the tail slots |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 3*N | Packed word {parity 2, parity 1, systematic} |
| out_sop | output | 1 | First word of a block |
| out_eop | output | 1 | Last word of a block |

## Verification
Two events can fall in the same cycle: the handover of the final tail word and the acceptance of the first beat of the next block. The output stage frees the slot in that cycle, so in_ready can rise while out_eop is still being handed over. The bench provokes this by offering the next block's first beat back to back with the tail. Downstream readiness is randomised, so the overlap happens both with and without a stall. The scoreboard judges the result by exact word order and flags, and a separate check requires in_ready to stay low on every earlier tail cycle.

// File: rtl/llr_fmt_pkg.sv
package llr_fmt_pkg;

  typedef enum logic {
    PH_DATA = 1'b0,
    PH_TAIL = 1'b1
  } phase_e;

  localparam int TAIL_SLOTS   = 12;
  localparam int SLOTS_PER_ENC = 6;
  localparam int TAIL_WORDS   = 4;

  // slot number of a tail LLR: encoder 0/1, parity flag, tail step 0..2
  function automatic int tail_slot(input int enc, input int is_par, input int step);
    return enc * SLOTS_PER_ENC + is_par * 3 + step;
  endfunction

endpackage

// File: rtl/llr_sanitize.sv
module llr_sanitize #(
  parameter int N = 6
) (
  input  logic [N-1:0] raw,
  input  logic         erased,
  output logic [N-1:0] clean
);
  localparam logic [N-1:0] CODE_FORBIDDEN = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] CODE_FLOOR     = {1'b1, {(N-2){1'b0}}, 1'b1};

  always_comb begin
    if (erased)                    clean = '0;
    else if (raw == CODE_FORBIDDEN) clean = CODE_FLOOR;
    else                           clean = raw;
  end
endmodule

// File: rtl/tail_word_sel.sv
module tail_word_sel
  import llr_fmt_pkg::*;
#(
  parameter int N = 6
) (
  input  logic [TAIL_SLOTS*N-1:0] slots,
  input  logic [1:0]              sel,
  output logic [3*N-1:0]          word
);
  logic [N-1:0] sys_t [2][3];
  logic [N-1:0] par_t [2][3];

  for (genvar e = 0; e < 2; e++) begin : g_enc
    for (genvar t = 0; t < 3; t++) begin : g_step
      assign sys_t[e][t] = slots[tail_slot(e, 0, t)*N +: N];
      assign par_t[e][t] = slots[tail_slot(e, 1, t)*N +: N];
    end
  end

  always_comb begin
    if (!sel[0]) word = {sys_t[sel[1]][1], par_t[sel[1]][0], sys_t[sel[1]][0]};
    else         word = {par_t[sel[1]][2], sys_t[sel[1]][2], par_t[sel[1]][1]};
  end
endmodule

// File: rtl/llr_out_stage.sv
module llr_out_stage #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         load_sop,
  input  logic         load_eop,
  output logic         slot_free,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_sop,
  output logic         out_eop
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
    end else if (slot_free) begin
      out_valid <= load;
      if (load) begin
        out_data <= load_data;
        out_sop  <= load_sop;
        out_eop  <= load_eop;
      end
    end
  end
endmodule

// File: rtl/llr_stream_packer.sv
module llr_stream_packer
  import llr_fmt_pkg::*;
#(
  parameter int N     = 6,
  parameter int K_MAX = 6144,
  parameter int KW    = $clog2(K_MAX + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [KW-1:0]           cfg_k,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [N-1:0]            in_sys,
  input  logic [N-1:0]            in_par1,
  input  logic [N-1:0]            in_par2,
  input  logic [2:0]              in_punct,
  input  logic [TAIL_SLOTS*N-1:0] in_tail,
  input  logic [TAIL_SLOTS-1:0]   in_tail_punct,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [3*N-1:0]          out_data,
  output logic                    out_sop,
  output logic                    out_eop
);
  localparam int WW = 3 * N;
  localparam int TW = TAIL_SLOTS * N;

  phase_e          phase;
  logic [KW-1:0]   idx;
  logic [KW-1:0]   k_held;
  logic [1:0]      tsel;
  logic [TW-1:0]   tail_bank;

  logic            slot_free;
  logic            take_data;
  logic            take_tail;
  logic [KW-1:0]   k_eff;
  logic            last_data;
  logic [3*N-1:0]  data_word;
  logic [3*N-1:0]  tail_word;
  logic [TW-1:0]   tail_clean;
  logic [N-1:0]    raw_f [3];
  logic [N-1:0]    cln_f [3];

  assign raw_f[0] = in_sys;
  assign raw_f[1] = in_par1;
  assign raw_f[2] = in_par2;

  for (genvar f = 0; f < 3; f++) begin : g_data_clean
    llr_sanitize #(.N(N)) u_san (
      .raw   (raw_f[f]),
      .erased(in_punct[f]),
      .clean (cln_f[f])
    );
  end
  assign data_word = {cln_f[2], cln_f[1], cln_f[0]};

  for (genvar s = 0; s < TAIL_SLOTS; s++) begin : g_tail_clean
    llr_sanitize #(.N(N)) u_san (
      .raw   (in_tail[s*N +: N]),
      .erased(in_tail_punct[s]),
      .clean (tail_clean[s*N +: N])
    );
  end

  tail_word_sel #(.N(N)) u_tsel (
    .slots(tail_bank),
    .sel  (tsel),
    .word (tail_word)
  );

  assign in_ready  = (phase == PH_DATA) && slot_free;
  assign take_data = in_valid && in_ready;
  assign take_tail = (phase == PH_TAIL) && slot_free;
  assign k_eff     = (idx == '0) ? cfg_k : k_held;
  assign last_data = (idx == KW'(k_eff - KW'(1)));

  llr_out_stage #(.W(WW)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (take_data || take_tail),
    .load_data(take_tail ? tail_word : data_word),
    .load_sop (take_data && (idx == '0)),
    .load_eop (take_tail && (tsel == 2'd3)),
    .slot_free(slot_free),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_sop  (out_sop),
    .out_eop  (out_eop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_DATA;
      idx       <= '0;
      k_held    <= '0;
      tsel      <= '0;
      tail_bank <= '0;
    end else begin
      if (take_data) begin
        if (idx == '0) k_held <= cfg_k;
        if (last_data) begin
          phase     <= PH_TAIL;
          idx       <= '0;
          tsel      <= '0;
          tail_bank <= tail_clean;
        end else begin
          idx <= idx + KW'(1);
        end
      end
      if (take_tail) begin
        tsel <= tsel + 2'd1;
        if (tsel == 2'd3) phase <= PH_DATA;
      end
    end
  end
endmodule

// File: rtl/llr_fmt_checker.sv
module llr_fmt_checker #(
  parameter int N = 6
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic [2:0]     in_punct,
  input logic           out_valid,
  input logic           out_ready,
  input logic [3*N-1:0] out_data,
  input logic           out_sop,
  input logic           out_eop
);
  localparam logic [N-1:0] BAD = {1'b1, {(N-1){1'b0}}};

  // R10: a stalled word holds
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));

  // R2: forbidden code never leaves the block
  a_r2_no_forbidden: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data[N-1:0] != BAD) && (out_data[2*N-1:N] != BAD) && (out_data[3*N-1:2*N] != BAD));

  // R3: erased systematic field appears as zero on the next word
  a_r3_erase_sys: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_punct[0] |=> out_valid && (out_data[N-1:0] == '0));

  // R3: erased parity-2 field appears as zero
  a_r3_erase_par2: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_punct[2] |=> out_valid && (out_data[3*N-1:2*N] == '0));

  // R8: start and end never mark the same word (block has at least five words)
  a_r8_sop_eop_apart: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_sop && out_eop));

  // R10: every accepted beat reaches the output register
  a_r10_no_drop: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);
endmodule

bind llr_stream_packer llr_fmt_checker #(.N(N)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_punct (in_punct),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_sop  (out_sop),
  .out_eop  (out_eop)
);

// File: tb/sim_llr_stream_packer.sv
`timescale 1ns/1ps
module sim_llr_stream_packer;
  localparam int N  = 6;
  localparam int KM = 6144;
  localparam int KW = $clog2(KM + 1);
  localparam int TS = 12;
  localparam logic [N-1:0] BAD   = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] FLOOR = {1'b1, {(N-2){1'b0}}, 1'b1};

  typedef struct {
    logic [3*N-1:0] data;
    logic           sop;
    logic           eop;
    string          tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [KW-1:0] cfg_k = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [N-1:0] in_sys = '0, in_par1 = '0, in_par2 = '0;
  logic [2:0] in_punct = '0;
  logic [TS*N-1:0] in_tail = '0;
  logic [TS-1:0] in_tail_punct = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [3*N-1:0] out_data;
  logic out_sop, out_eop;

  int checks = 0;
  int failures = 0;
  int bp_on = 0;
  bit tail_pending = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  llr_stream_packer #(.N(N), .K_MAX(KM)) u0 (
    .clk(clk), .rst(rst), .cfg_k(cfg_k),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_sys(in_sys), .in_par1(in_par1), .in_par2(in_par2), .in_punct(in_punct),
    .in_tail(in_tail), .in_tail_punct(in_tail_punct),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
  );

  function automatic logic [N-1:0] clean(input logic [N-1:0] v, input logic e);
    if (e) return '0;
    if (v == BAD) return FLOOR;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] pick(input int mode);
    logic [N-1:0] v;
    v = N'($urandom);
    if (mode == 1) v = BAD;
    else if (($urandom % 5) == 0) v = BAD;
    return v;
  endfunction

  // mode 0: random, 1: all forbidden code, 2: all erased
  task automatic send_block(input int k, input int mode, input int k_alt);
    logic [N-1:0] s [], p1 [], p2 [];
    logic [2:0] pm [];
    logic [TS*N-1:0] tl;
    logic [TS-1:0] tp;
    logic [N-1:0] c [TS];
    exp_t e;
    s = new[k]; p1 = new[k]; p2 = new[k]; pm = new[k];
    for (int j = 0; j < TS; j++) begin
      tl[j*N +: N] = pick(mode);
      tp[j] = (mode == 2) ? 1'b1 : (mode == 1 ? 1'b0 : 1'(($urandom % 4) == 0));
      c[j] = clean(tl[j*N +: N], tp[j]);
    end
    for (int i = 0; i < k; i++) begin
      s[i] = pick(mode); p1[i] = pick(mode); p2[i] = pick(mode);
      pm[i] = (mode == 2) ? 3'b111 : (mode == 1 ? 3'b000 : 3'($urandom));
      e.data = {clean(p2[i], pm[i][2]), clean(p1[i], pm[i][1]), clean(s[i], pm[i][0])};
      e.sop = (i == 0); e.eop = 1'b0;
      e.tag = "R1/R2/R3/R7/R8";
      sb.push_back(e);
    end
    // R4: first encoder; R5: second encoder; R6: tail cleaning
    for (int enc = 0; enc < 2; enc++) begin
      e.sop = 1'b0;
      e.data = {c[enc*6+1], c[enc*6+3], c[enc*6+0]};
      e.eop = 1'b0; e.tag = (enc == 0) ? "R4/R6" : "R5/R6";
      sb.push_back(e);
      e.data = {c[enc*6+5], c[enc*6+2], c[enc*6+4]};
      e.eop = (enc == 1); e.tag = (enc == 0) ? "R4/R6" : "R5/R6/R8";
      sb.push_back(e);
    end
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      cfg_k = (i == 0) ? KW'(k) : KW'(k_alt);
      in_valid = 1'b1;
      in_sys = s[i]; in_par1 = p1[i]; in_par2 = p2[i]; in_punct = pm[i];
      in_tail = tl; in_tail_punct = tp;
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
      if (i == k - 1) tail_pending = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // downstream readiness
  always @(posedge clk) begin
    #1 out_ready <= (bp_on != 0) ? 1'(($urandom % 3) != 0) : 1'b1;
  end

  // monitor
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (tail_pending && !(out_valid && out_ready && out_eop))
        check(in_ready == 1'b0, "R9 in_ready during tail", 64'(in_ready), 64'd0);
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R10 unexpected word", 64'(out_data), 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(out_data == e.data, e.tag, 64'(out_data), 64'(e.data));
          check({out_sop, out_eop} == {e.sop, e.eop}, "R8 flags", 64'({out_sop, out_eop}), 64'({e.sop, e.eop}));
          if (out_eop) tail_pending = 1'b0;
        end
      end
    end
  end

  task automatic drain();
    int guard = 0;
    while ((sb.size() != 0 || out_valid) && guard < 2000) begin
      @(posedge clk);
      guard++;
    end
    check(sb.size() == 0, "R10 words missing", 64'(sb.size()), 64'd0);
  endtask

  task automatic run_tests();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(out_valid == 1'b0, "R11 out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R11 in_ready after reset", 64'(in_ready), 64'd1);
    send_block(1, 0, 1);                      // R1 smallest K
    send_block(3, 0, 3);
    drain();
    bp_on = 1;
    send_block(8, 0, 8);                      // R10 with stalls
    send_block(5, 1, 5);                      // R2 all forbidden codes
    send_block(4, 2, 4);                      // R3 all erased
    send_block(3, 0, 9);                      // R7 cfg_k change mid-block
    drain();
    bp_on = 0;
    send_block(2, 0, 1);                      // R7 change to smaller value
    send_block(6, 0, 6);                      // R9 back-to-back with tail
    drain();
    bp_on = 1;
    for (int b = 0; b < 6; b++) send_block(1 + int'($urandom % 12), 0, 1 + int'($urandom % 12));
    drain();
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 64'd0, 64'd1);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule